// File: doc/BRIEF.md
# Warm reboot address and fallback controller

This block keeps the small set of registers that decide where a configurable device loads its next image after a warm reboot. It holds two address pairs, one for the regular update image and one for the golden fallback image, plus a free scratchpad word, a mode word that can override the sampled strap pins, a watchdog reload value and an option word. A plain register port (write strobe, address, write data, combinational read data) reaches all of them. Every general and mode register is cleared only by the power-on reset, so anything written before a soft reboot survives it.

A sequencer starts a watchdog on each configuration attempt. The watchdog waits for the sync word. On a reboot request, the sequencer drives a registered bundle: read opcode, start address, bus width, boot mode and image select. It also raises a one-cycle start pulse. If the sync word never arrives during an update-image attempt, it sets a fallback flag and relaunches from the golden image. If the golden attempt also times out, it stops in a fatal state.

The sequencer has four states. IDLE waits for work. BOOT is the single cycle in which the start pulse and bundle are shown. WAIT_SYNC runs the watchdog. FATAL holds the error. The transitions are as follows:
- IDLE to BOOT on a reboot request.
- IDLE to WAIT_SYNC on an attempt start.
- BOOT to WAIT_SYNC always.
- WAIT_SYNC to IDLE on sync.
- WAIT_SYNC to BOOT on expiry with the fallback flag clear, or on a reboot request.
- WAIT_SYNC to FATAL on expiry with the fallback flag set.
- FATAL stays in FATAL until a soft or power-on reset, which returns the sequencer to IDLE.

Top module: `reboot_steer`

## Requirements
- R1: After power-on reset, registers 0 to 4, 5 (stored bits) and 7 read 0, and register 6 (watchdog reload) reads 16'hFFFF. The outputs boot_start, fatal_err and skip_init are 0.
- R2: The register map is 0 update-image low word, 1 update-image high word, 2 golden low word, 3 golden high word, 4 scratchpad, 5 mode, 6 watchdog reload, 7 option. Register 5 stores only bits 15, 12:11 and 9:8; bits 14:13 and 10 read 0, and bits 7:0 always read pin_vsel, whatever is written.
- R3: A write to register 6 below 16'h0201 stores 16'h0201. Any other value is stored as written.
- R4: With flash_par=0 (serial flash), the launched opcode is high-word bits 15:8. The launched address is {2'b00, high[7:0], low[15:0]}.
- R5: With flash_par=1 (parallel flash), the address is {high[9:0], low[15:0]}, high bits 15:10 are ignored, and the opcode is 8'h00.
- R6: When mode bit 15 is 1, boot_width is mode bits 12:11 and boot_mode is mode bits 9:8. When mode bit 15 is 0, they come from pin_width and pin_boot.
- R7: A soft reset leaves registers 0 to 7 and the fallback flag unchanged. It returns the sequencer to IDLE, which clears fatal_err.
- R8: A reboot request seen at a clock edge shows boot_start=1 with the bundle after that edge. boot_start is high for exactly one cycle.
- R9: An attempt start seen at edge E0 loads the reload value N. Without sync, boot_start rises after edge E0+N+1 with boot_golden=1 and the golden address, and the fallback flag is set.
- R10: A timeout while the fallback flag is set enters FATAL (fatal_err=1) without a start pulse. FATAL ignores reboot requests.
- R11: sync_seen during WAIT_SYNC returns the sequencer to IDLE and clears the fallback flag. It wins over an expiry in the same cycle.
- R12: skip_init follows option register bit 6. The other option bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous reboot-triggered reset, registers kept |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| pin_vsel | input | 8 | Sampled voltage-select straps |
| pin_width | input | 2 | Sampled bus-width straps |
| pin_boot | input | 2 | Sampled boot-mode straps |
| flash_par | input | 1 | 1 selects parallel flash address format |
| cfg_start | input | 1 | A configuration attempt begins |
| sync_seen | input | 1 | Sync word detected |
| reboot_req | input | 1 | Reboot request |
| boot_start | output | 1 | One-cycle launch pulse |
| boot_opcode | output | 8 | Flash read opcode |
| boot_addr | output | 26 | Start address of the image |
| boot_width | output | 2 | Bus width for the attempt |
| boot_mode | output | 2 | Boot mode for the attempt |
| boot_golden | output | 1 | 1 when the golden image is launched |
| fatal_err | output | 1 | Golden attempt timed out |
| skip_init | output | 1 | Skip-initialization option |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 16-bit watchdog and a floor of 16'h0201. Because the floor clamps short writes, a watchdog window of 513 cycles is the shortest a bench can force. Two full timeouts back to back, one from the update image and one from the golden image, therefore fit in about a thousand cycles. This makes the expiry edge, the golden relaunch, the fatal stop and a sync arriving on the expiry cycle all reachable directly, next to randomized address and mode checks in both flash formats.

// File: rtl/reboot_steer_pkg.sv
package reboot_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BOOT,
        ST_WAIT,
        ST_FATAL
    } seq_state_t;

    localparam int unsigned IDX_IMG_LO  = 0;
    localparam int unsigned IDX_IMG_HI  = 1;
    localparam int unsigned IDX_GLD_LO  = 2;
    localparam int unsigned IDX_GLD_HI  = 3;
    localparam int unsigned IDX_SCRATCH = 4;
    localparam int unsigned IDX_MODE    = 5;
    localparam int unsigned IDX_WDOG    = 6;
    localparam int unsigned IDX_OPT     = 7;
    localparam int unsigned GEN_COUNT   = 5;

    localparam int unsigned MODE_OVR_BIT  = 15;
    localparam int unsigned MODE_WID_LSB  = 11;
    localparam int unsigned MODE_BOOT_LSB = 8;
    localparam int unsigned OPT_SKIP_BIT  = 6;
    localparam int unsigned OPCODE_W      = 8;
    localparam int unsigned PAR_HI_BITS   = 10;
    localparam int unsigned SER_HI_BITS   = 8;

endpackage

// File: rtl/rs_regfile.sv
module rs_regfile
    import reboot_steer_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned RADDR_W = 3,
    parameter int unsigned WD_W    = 16,
    parameter logic [WD_W-1:0] WD_MIN = 16'h0201
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               soft_rst,
    input  logic               we,
    input  logic [RADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [7:0]         pin_vsel,
    output logic [DATA_W-1:0]  img_lo,
    output logic [DATA_W-1:0]  img_hi,
    output logic [DATA_W-1:0]  gld_lo,
    output logic [DATA_W-1:0]  gld_hi,
    output logic [DATA_W-1:0]  mode_q,
    output logic [WD_W-1:0]    wd_reload,
    output logic               skip_init
);

    localparam logic [DATA_W-1:0] MODE_KEEP =
        DATA_W'((1 << MODE_OVR_BIT) | (3 << MODE_WID_LSB) | (3 << MODE_BOOT_LSB));

    logic [DATA_W-1:0] gen_w [GEN_COUNT];
    logic [WD_W-1:0]   wd_q;
    logic              skip_q;

    // one storage word per general register
    for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
                word_q <= '0;
            else if (we && addr == RADDR_W'(g))
                word_q <= wdata;
        end
        assign gen_w[g] = word_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mode_q <= '0;
            wd_q   <= '1;
            skip_q <= 1'b0;
        end else if (we) begin
            if (addr == RADDR_W'(IDX_MODE))
                mode_q <= wdata & MODE_KEEP;
            if (addr == RADDR_W'(IDX_WDOG))
                wd_q <= (wdata[WD_W-1:0] < WD_MIN) ? WD_MIN : wdata[WD_W-1:0];
            if (addr == RADDR_W'(IDX_OPT))
                skip_q <= wdata[OPT_SKIP_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RADDR_W'(IDX_IMG_LO):  rdata = gen_w[IDX_IMG_LO];
            RADDR_W'(IDX_IMG_HI):  rdata = gen_w[IDX_IMG_HI];
            RADDR_W'(IDX_GLD_LO):  rdata = gen_w[IDX_GLD_LO];
            RADDR_W'(IDX_GLD_HI):  rdata = gen_w[IDX_GLD_HI];
            RADDR_W'(IDX_SCRATCH): rdata = gen_w[IDX_SCRATCH];
            RADDR_W'(IDX_MODE):    rdata = mode_q | DATA_W'(pin_vsel);
            RADDR_W'(IDX_WDOG):    rdata = DATA_W'(wd_q);
            RADDR_W'(IDX_OPT):     rdata = DATA_W'(skip_q) << OPT_SKIP_BIT;
            default:               rdata = '0;
        endcase
    end

    assign img_lo    = gen_w[IDX_IMG_LO];
    assign img_hi    = gen_w[IDX_IMG_HI];
    assign gld_lo    = gen_w[IDX_GLD_LO];
    assign gld_hi    = gen_w[IDX_GLD_HI];
    assign wd_reload = wd_q;
    assign skip_init = skip_q;

    // R3: the stored reload never drops below the floor
    p_reload_floor_r3: assert property (@(posedge clk) disable iff (!por_n)
        wd_q >= WD_MIN);

    // R7: a soft reset without a write leaves stored words alone
    p_soft_keeps_r7: assert property (@(posedge clk) disable iff (!por_n)
        (soft_rst && !we) |=> ($stable(mode_q) && $stable(wd_q) &&
                               $stable(gen_w[IDX_IMG_HI]) && $stable(gen_w[IDX_GLD_HI])));

endmodule

// File: rtl/rs_watchdog.sv
module rs_watchdog #(
    parameter int unsigned WD_W = 16
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            soft_rst,
    input  logic            load,
    input  logic            run,
    input  logic [WD_W-1:0] reload,
    output logic            expired
);

    logic [WD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cnt_q <= '0;
        else if (soft_rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= reload;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q == '0);

    // R9: a reload lands exactly on the programmed value
    p_load_value_r9: assert property (@(posedge clk) disable iff (!por_n)
        (load && !soft_rst) |=> cnt_q == $past(reload));

    // R9: a running count steps down by one per cycle
    p_count_step_r9: assert property (@(posedge clk) disable iff (!por_n)
        (run && !load && !soft_rst && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import reboot_steer_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned AW     = DATA_W + PAR_HI_BITS
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              reboot_req,
    input  logic              cfg_start,
    input  logic              sync_seen,
    input  logic              expired,
    input  logic              flash_par,
    input  logic [1:0]        pin_width,
    input  logic [1:0]        pin_boot,
    input  logic [DATA_W-1:0] img_lo,
    input  logic [DATA_W-1:0] img_hi,
    input  logic [DATA_W-1:0] gld_lo,
    input  logic [DATA_W-1:0] gld_hi,
    input  logic [DATA_W-1:0] mode_q,
    output logic              wd_load,
    output logic              wd_run,
    output logic              boot_start,
    output logic [OPCODE_W-1:0] boot_opcode,
    output logic [AW-1:0]     boot_addr,
    output logic [1:0]        boot_width,
    output logic [1:0]        boot_mode,
    output logic              boot_golden,
    output logic              fatal_err
);

    seq_state_t state_q, state_nx;
    logic       fallback_q;
    logic       launch, launch_gold, set_fb, clr_fb;

    logic [DATA_W-1:0]   sel_lo, sel_hi;
    logic [OPCODE_W-1:0] nx_opcode;
    logic [AW-1:0]       nx_addr;
    logic [1:0]          nx_width, nx_mode;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= ST_IDLE;
        else if (soft_rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // next state and decisions
    always_comb begin
        state_nx    = state_q;
        launch      = 1'b0;
        launch_gold = fallback_q;
        set_fb      = 1'b0;
        clr_fb      = 1'b0;
        wd_load     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (reboot_req) begin
                    state_nx = ST_BOOT;
                    launch   = 1'b1;
                end else if (cfg_start) begin
                    state_nx = ST_WAIT;
                    wd_load  = 1'b1;
                end
            end
            ST_BOOT: begin
                state_nx = ST_WAIT;
                wd_load  = 1'b1;
            end
            ST_WAIT: begin
                if (sync_seen) begin
                    state_nx = ST_IDLE;
                    clr_fb   = 1'b1;
                end else if (expired) begin
                    if (fallback_q) begin
                        state_nx = ST_FATAL;
                    end else begin
                        state_nx    = ST_BOOT;
                        launch      = 1'b1;
                        launch_gold = 1'b1;
                        set_fb      = 1'b1;
                    end
                end else if (reboot_req) begin
                    state_nx = ST_BOOT;
                    launch   = 1'b1;
                end else if (cfg_start) begin
                    wd_load = 1'b1;
                end
            end
            ST_FATAL: state_nx = ST_FATAL;
        endcase
        if (soft_rst) begin
            launch  = 1'b0;
            set_fb  = 1'b0;
            clr_fb  = 1'b0;
            wd_load = 1'b0;
        end
    end

    assign wd_run    = (state_q == ST_WAIT);
    assign fatal_err = (state_q == ST_FATAL);

    // fallback flag survives soft resets
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            fallback_q <= 1'b0;
        else if (clr_fb)
            fallback_q <= 1'b0;
        else if (set_fb)
            fallback_q <= 1'b1;
    end

    // bundle formatting
    always_comb begin
        sel_lo    = launch_gold ? gld_lo : img_lo;
        sel_hi    = launch_gold ? gld_hi : img_hi;
        nx_opcode = flash_par ? '0 : sel_hi[DATA_W-1 -: OPCODE_W];
        nx_addr   = flash_par ? {sel_hi[PAR_HI_BITS-1:0], sel_lo}
                              : AW'({sel_hi[SER_HI_BITS-1:0], sel_lo});
        nx_width  = mode_q[MODE_OVR_BIT] ? mode_q[MODE_WID_LSB +: 2] : pin_width;
        nx_mode   = mode_q[MODE_OVR_BIT] ? mode_q[MODE_BOOT_LSB +: 2] : pin_boot;
    end

    // registered outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            boot_start  <= 1'b0;
            boot_opcode <= '0;
            boot_addr   <= '0;
            boot_width  <= '0;
            boot_mode   <= '0;
            boot_golden <= 1'b0;
        end else begin
            boot_start <= launch;
            if (launch) begin
                boot_opcode <= nx_opcode;
                boot_addr   <= nx_addr;
                boot_width  <= nx_width;
                boot_mode   <= nx_mode;
                boot_golden <= launch_gold;
            end
        end
    end

    // R8: the start pulse lasts one cycle
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!por_n)
        boot_start |=> !boot_start);

    // R10: fatal holds until a reset
    p_fatal_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (fatal_err && !soft_rst) |=> fatal_err);

    // R10: no launch while fatal
    p_fatal_quiet_r10: assert property (@(posedge clk) disable iff (!por_n)
        fatal_err |-> !boot_start);

    // R11: sync returns to idle with the flag cleared
    p_sync_clears_r11: assert property (@(posedge clk) disable iff (!por_n)
        (wd_run && sync_seen && !soft_rst) |=> (state_q == ST_IDLE && !fallback_q));

    // R9: an expiry launch always picks the golden image
    p_expiry_gold_r9: assert property (@(posedge clk) disable iff (!por_n)
        (wd_run && expired && !sync_seen && !fallback_q && !soft_rst) |=> (boot_start && boot_golden));

endmodule

// File: rtl/reboot_steer.sv
module reboot_steer
    import reboot_steer_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned RADDR_W = 3,
    parameter int unsigned WD_W    = 16,
    parameter logic [WD_W-1:0] WD_MIN = 16'h0201,
    localparam int unsigned AW = DATA_W + PAR_HI_BITS
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               soft_rst,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [7:0]         pin_vsel,
    input  logic [1:0]         pin_width,
    input  logic [1:0]         pin_boot,
    input  logic               flash_par,
    input  logic               cfg_start,
    input  logic               sync_seen,
    input  logic               reboot_req,
    output logic               boot_start,
    output logic [OPCODE_W-1:0] boot_opcode,
    output logic [AW-1:0]      boot_addr,
    output logic [1:0]         boot_width,
    output logic [1:0]         boot_mode,
    output logic               boot_golden,
    output logic               fatal_err,
    output logic               skip_init
);

    logic [DATA_W-1:0] img_lo, img_hi, gld_lo, gld_hi, mode_q;
    logic [WD_W-1:0]   wd_reload;
    logic              wd_load, wd_run, wd_expired;

    rs_regfile #(
        .DATA_W (DATA_W),
        .RADDR_W(RADDR_W),
        .WD_W   (WD_W),
        .WD_MIN (WD_MIN)
    ) u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .pin_vsel (pin_vsel),
        .img_lo   (img_lo),
        .img_hi   (img_hi),
        .gld_lo   (gld_lo),
        .gld_hi   (gld_hi),
        .mode_q   (mode_q),
        .wd_reload(wd_reload),
        .skip_init(skip_init)
    );

    rs_watchdog #(
        .WD_W(WD_W)
    ) u_wdog (
        .clk     (clk),
        .por_n   (por_n),
        .soft_rst(soft_rst),
        .load    (wd_load),
        .run     (wd_run),
        .reload  (wd_reload),
        .expired (wd_expired)
    );

    rs_seq #(
        .DATA_W(DATA_W),
        .AW    (AW)
    ) u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst   (soft_rst),
        .reboot_req (reboot_req),
        .cfg_start  (cfg_start),
        .sync_seen  (sync_seen),
        .expired    (wd_expired),
        .flash_par  (flash_par),
        .pin_width  (pin_width),
        .pin_boot   (pin_boot),
        .img_lo     (img_lo),
        .img_hi     (img_hi),
        .gld_lo     (gld_lo),
        .gld_hi     (gld_hi),
        .mode_q     (mode_q),
        .wd_load    (wd_load),
        .wd_run     (wd_run),
        .boot_start (boot_start),
        .boot_opcode(boot_opcode),
        .boot_addr  (boot_addr),
        .boot_width (boot_width),
        .boot_mode  (boot_mode),
        .boot_golden(boot_golden),
        .fatal_err  (fatal_err)
    );

endmodule

// File: tb/reboot_steer_bench.sv
module reboot_steer_bench;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  pin_vsel = 8'h5A;
    logic [1:0]  pin_width = 2'b00;
    logic [1:0]  pin_boot = 2'b01;
    logic        flash_par = 1'b0;
    logic        cfg_start = 1'b0;
    logic        sync_seen = 1'b0;
    logic        reboot_req = 1'b0;
    logic        boot_start;
    logic [7:0]  boot_opcode;
    logic [25:0] boot_addr;
    logic [1:0]  boot_width;
    logic [1:0]  boot_mode;
    logic        boot_golden;
    logic        fatal_err;
    logic        skip_init;

    int nchk = 0;
    int nerr = 0;
    logic [15:0] sh [8];
    localparam int unsigned NFLOOR = 16'h0201;

    always #10 clk = ~clk;

    reboot_steer u_reboot_steer (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_vsel(pin_vsel), .pin_width(pin_width), .pin_boot(pin_boot),
        .flash_par(flash_par), .cfg_start(cfg_start), .sync_seen(sync_seen),
        .reboot_req(reboot_req), .boot_start(boot_start), .boot_opcode(boot_opcode),
        .boot_addr(boot_addr), .boot_width(boot_width), .boot_mode(boot_mode),
        .boot_golden(boot_golden), .fatal_err(fatal_err), .skip_init(skip_init)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_rd(input int a);
        case (a)
            5:       return (sh[5] & 16'h9B00) | {8'h00, pin_vsel};
            7:       return sh[7] & 16'h0040;
            default: return sh[a];
        endcase
    endfunction

    function automatic logic [15:0] clamp_wd(input logic [15:0] v);
        return (v < 16'h0201) ? 16'h0201 : v;
    endfunction

    function automatic logic [25:0] exp_addr(input logic gold);
        logic [15:0] lo = gold ? sh[2] : sh[0];
        logic [15:0] hi = gold ? sh[3] : sh[1];
        return flash_par ? {hi[9:0], lo} : {2'b00, hi[7:0], lo};
    endfunction

    function automatic logic [7:0] exp_op(input logic gold);
        logic [15:0] hi = gold ? sh[3] : sh[1];
        return flash_par ? 8'h00 : hi[15:8];
    endfunction

    function automatic logic [1:0] exp_w();
        return sh[5][15] ? sh[5][12:11] : pin_width;
    endfunction

    function automatic logic [1:0] exp_m();
        return sh[5][15] ? sh[5][9:8] : pin_boot;
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        step();
        reg_we = 1'b0;
        sh[a] = (a == 6) ? clamp_wd(d) : d;
    endtask

    task automatic rd_chk(input string tag, input int a);
        reg_addr = 3'(a);
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp_rd(a)));
    endtask

    task automatic launch_chk(input string tag, input logic gold);
        reboot_req = 1'b1;
        step();
        reboot_req = 1'b0;
        chk({tag, " start"}, 32'(boot_start), 32'd1);
        chk({tag, " golden"}, 32'(boot_golden), 32'(gold));
        chk({tag, " addr"}, 32'(boot_addr), 32'(exp_addr(gold)));
        chk({tag, " opcode"}, 32'(boot_opcode), 32'(exp_op(gold)));
        chk({tag, " width"}, 32'(boot_width), 32'(exp_w()));
        chk({tag, " mode"}, 32'(boot_mode), 32'(exp_m()));
        step();
        chk("R8 pulse one cycle", 32'(boot_start), 32'd0);
    endtask

    task automatic do_sync();
        sync_seen = 1'b1;
        step();
        sync_seen = 1'b0;
    endtask

    initial begin
        #4_000_000;
        nerr++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 8; i++) sh[i] = 16'h0000;
        sh[6] = 16'hFFFF;
        repeat (3) step();
        por_n = 1'b1;
        step();

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", a);
        chk("R1 boot_start", 32'(boot_start), 32'd0);
        chk("R1 fatal_err", 32'(fatal_err), 32'd0);
        chk("R1 skip_init", 32'(skip_init), 32'd0);

        // R2 mode field masking and read-only vsel
        wr(5, 16'hFFFF);
        rd_chk("R2 mode mask", 5);
        pin_vsel = 8'hC3;
        rd_chk("R2 vsel follows pins", 5);
        wr(4, 16'hBEEF);
        rd_chk("R2 scratch", 4);

        // R12 option bit
        wr(7, 16'hFFFF);
        rd_chk("R12 option read", 7);
        chk("R12 skip_init set", 32'(skip_init), 32'd1);
        wr(7, 16'h0040 ^ 16'hFFFF);
        chk("R12 skip_init clear", 32'(skip_init), 32'd0);

        // R3 reload floor
        wr(6, 16'h0005);  rd_chk("R3 clamp small", 6);
        wr(6, 16'h0200);  rd_chk("R3 clamp one below", 6);
        wr(6, 16'h0201);  rd_chk("R3 exact floor", 6);
        wr(6, 16'h0000);  rd_chk("R3 clamp zero", 6);
        wr(6, 16'h1234);  rd_chk("R3 pass through", 6);

        // directed format corners: R4 serial, R5 parallel, R6 pins
        wr(0, 16'h1357); wr(1, 16'hABCD); wr(5, 16'h0000);
        flash_par = 1'b0;
        launch_chk("R4 serial directed", 1'b0);
        do_sync();
        flash_par = 1'b1;
        launch_chk("R5 parallel directed", 1'b0);
        do_sync();
        wr(5, 16'h8000 | (16'h2 << 11) | (16'h3 << 8));
        launch_chk("R6 override directed", 1'b0);
        do_sync();

        // randomized R4 R5 R6 R8
        for (int it = 0; it < 30; it++) begin
            for (int a = 0; a < 4; a++) wr(a, 16'($urandom));
            wr(5, 16'($urandom));
            flash_par = 1'($urandom);
            pin_width = 2'($urandom);
            pin_boot  = 2'($urandom);
            pin_vsel  = 8'($urandom);
            rd_chk("R2 random mode read", 5);
            launch_chk(flash_par ? "R5 random launch" : "R4 random launch", 1'b0);
            do_sync();
        end

        // R9 timeout to golden, R10 fatal
        wr(6, 16'h0005);
        flash_par = 1'b0;
        wr(2, 16'h2468); wr(3, 16'h0B9A);
        cfg_start = 1'b1;
        step();
        cfg_start = 1'b0;
        repeat (NFLOOR) step();
        chk("R9 no start before expiry", 32'(boot_start), 32'd0);
        step();
        chk("R9 start at expiry", 32'(boot_start), 32'd1);
        chk("R9 golden selected", 32'(boot_golden), 32'd1);
        chk("R9 golden addr", 32'(boot_addr), 32'(exp_addr(1'b1)));
        chk("R9 golden opcode", 32'(boot_opcode), 32'(exp_op(1'b1)));
        repeat (NFLOOR + 1) step();
        chk("R10 not fatal yet", 32'(fatal_err), 32'd0);
        step();
        chk("R10 fatal after golden timeout", 32'(fatal_err), 32'd1);
        chk("R10 no start into fatal", 32'(boot_start), 32'd0);
        reboot_req = 1'b1;
        step();
        reboot_req = 1'b0;
        chk("R10 request ignored start", 32'(boot_start), 32'd0);
        chk("R10 request ignored fatal", 32'(fatal_err), 32'd1);

        // R7 soft reset keeps registers and fallback flag
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        chk("R7 fatal cleared", 32'(fatal_err), 32'd0);
        for (int a = 0; a < 8; a++) rd_chk("R7 register kept", a);
        launch_chk("R7 fallback kept", 1'b1);

        // R11 sync clears the fallback flag
        do_sync();
        launch_chk("R11 flag cleared", 1'b0);
        do_sync();

        // R11 sync wins over expiry in the same cycle
        cfg_start = 1'b1;
        step();
        cfg_start = 1'b0;
        repeat (NFLOOR) step();
        do_sync();
        chk("R11 sync beats expiry", 32'(boot_start), 32'd0);
        repeat (3) step();
        chk("R11 no later start", 32'(boot_start), 32'd0);
        chk("R11 no fatal", 32'(fatal_err), 32'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule